// File: doc/BRIEF.md
# Start-Bit Random Number Controller

This block is a register-mapped random number source with a 32-bit access port. Software first programs a sample count. It then writes one control word that carries an enable, a start flag, a source-speed code and an output-length code. While a request runs, the block takes one entropy bit per sample period and packs the bits into a result buffer. When the requested number of bits is in place, it copies them into up to eight 32-bit output words in a single cycle and drops the start flag. Software polls that flag and then reads the words.

The entropy source is a seeded 32-bit linear feedback shift register. It advances only when a sample is taken, so the results are deterministic. A control write whose low 16 bits are all zero aborts a running request and disables the block.

The controller has two states. `ST_IDLE` waits for software. The *launch* transition goes from `ST_IDLE` to `ST_RUN` on a control write that has both start and enable set. `ST_RUN` collects samples. The *finish* transition returns to `ST_IDLE` when the last sample of the requested length is taken. The *abort* transition returns to `ST_IDLE` on a stop write.

Top module: `startbit_rng`

## Requirements
- R1: After reset, the control word reads 0x0, the sample count reads 0x0 and every output word reads 0x0.
- R2: The control word is at offset 0x400, with start at bit 0, enable at bit 1, speed at bits 3:2 and length at bits 5:4; it reads back the stored enable, speed and length, and start reads 1 exactly while a request runs. The sample count is at offset 0x404 and reads back its 16-bit value.
- R3: A control write with start=1 and enable=1 while idle launches a request; start then reads 1 until the request completes, exactly N*P cycles after the write, where N is the number of bits and P is the sample period.
- R4: The sample period P is the sample count multiplied by 1, 2, 4 or 8 for speed codes 0, 1, 2 and 3.
- R5: A sample count of 0 is treated as 1.
- R6: Length codes 0, 1, 2 and 3 request 64, 128, 192 and 256 bits, which fill 2, 4, 6 and 8 words at offsets 0x410 + 4*i. After completion, words beyond the requested length read 0.
- R7: The source is a 32-bit register seeded with 0xACE12468. At each sample it shifts right by one and, if the bit shifted out was 1, XORs in 0x80200003. The new bit 0 is the sampled bit. Sample k of a request lands in word k/32, bit k%32. The register advances only on samples and keeps its state between requests.
- R8: While a request runs, the output words keep their previous contents; all of them change together in the completion cycle.
- R9: A start request with enable=0 launches nothing; start stays 0, the output words are unchanged and the source does not advance. The other fields are still stored.
- R10: A control write whose low 16 bits are zero stops a running request, clears enable, speed and length, and leaves the output words unchanged. A sample due in the same cycle is not taken, even if it would have completed the request.
- R11: While a request runs, control writes that are not a stop are ignored. Sample-count writes are stored but do not change the period of the request already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write access when selected |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
A stop write and the final sample of a request can fall in the same cycle, so abort and finish compete in one edge. The bench provokes this by launching a request with a known period and writing the stop word exactly N*P cycles later. It judges the outcome at the ports: start must read 0, the output words must keep their old values, and the next full request must produce words that match a reference source advanced by only N-1 samples. A second collision, a non-stop control write and a sample-count write landing mid-request, is judged by an unchanged completion latency and result.

// File: rtl/srng_pkg.sv
package srng_pkg;
    localparam int WORD_W   = 32;
    localparam int CTRL_OFF = 'h400;
    localparam int SCNT_OFF = 'h404;
    localparam int OUT_OFF  = 'h410;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } srng_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic [1:0] speed;
        logic       en;
    } srng_ctrl_t;
endpackage

// File: rtl/srng_tick.sv
// Sample period timer: pulses once every per_i cycles while run_i is high.
module srng_tick #(
    parameter int PER_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PER_W-1:0] per_i,
    output logic             tick_o
);
    logic [PER_W-1:0] count_q;

    assign tick_o = run_i && (count_q == per_i - PER_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (!run_i || tick_o)
            count_q <= '0;
        else
            count_q <= count_q + PER_W'(1);
    end
endmodule

// File: rtl/srng_lfsr.sv
// Deterministic entropy model: Galois shift register stepped per sample.
module srng_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] SEED = 32'hACE1_2468,
    parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic bit_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] state_nxt;

    always_comb begin
        state_nxt = state_q >> 1;
        if (state_q[0])
            state_nxt = state_nxt ^ TAPS;
    end

    assign bit_o = state_nxt[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEED;
        else if (step_i)
            state_q <= state_nxt;
    end
endmodule

// File: rtl/srng_collect.sv
// Bit accumulator: the sample at position idx_i is written into the buffer.
module srng_collect #(
    parameter int BITS  = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             bit_i,
    output logic [BITS-1:0]  acc_nxt_o
);
    logic [BITS-1:0] acc_q;

    always_comb begin
        acc_nxt_o = acc_q;
        if (smp_i)
            acc_nxt_o[idx_i] = bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_nxt_o;
    end
endmodule

// File: rtl/startbit_rng.sv
module startbit_rng
    import srng_pkg::*;
#(
    parameter int          CNT_W  = 16,
    parameter int          ADDR_W = 12,
    parameter int          NWORDS = 8,
    parameter logic [31:0] SEED   = 32'hACE1_2468,
    parameter logic [31:0] TAPS   = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int MAX_SH     = 3;
    localparam int PER_W      = CNT_W + MAX_SH;
    localparam int BITS       = NWORDS * WORD_W;
    localparam int IDX_W      = $clog2(BITS);
    localparam int STEP_BITS  = BITS / 4;
    localparam int STEP_WORDS = NWORDS / 4;
    localparam int NW_W       = $clog2(NWORDS) + 1;

    srng_state_e state_q, state_d;
    srng_ctrl_t  ctrl_q;
    logic [CNT_W-1:0]             scnt_q;
    logic [PER_W-1:0]             per_q;
    logic [IDX_W-1:0]             idx_q;
    logic [NWORDS-1:0][WORD_W-1:0] out_q;
    logic [BITS-1:0]              acc_nxt;

    logic wr_ctrl, wr_scnt, stop_req, launch_req;
    logic busy, run_en, smp_tick, smp_bit, finish;
    logic [IDX_W-1:0] last_idx;
    logic [NW_W-1:0]  nwords_req;
    logic [CNT_W-1:0] eff_cnt;

    // register decode
    assign wr_ctrl    = bus_sel && bus_wr && (bus_addr == ADDR_W'(CTRL_OFF));
    assign wr_scnt    = bus_sel && bus_wr && (bus_addr == ADDR_W'(SCNT_OFF));
    assign stop_req   = wr_ctrl && (bus_wdata[15:0] == 16'h0000);
    assign launch_req = wr_ctrl && bus_wdata[0] && bus_wdata[1];
    assign eff_cnt    = (scnt_q == '0) ? CNT_W'(1) : scnt_q;
    assign last_idx   = IDX_W'((int'(ctrl_q.len) + 1) * STEP_BITS - 1);
    assign nwords_req = NW_W'((int'(ctrl_q.len) + 1) * STEP_WORDS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state: launch, finish, abort
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch_req) state_d = ST_RUN;
            ST_RUN: begin
                if (stop_req)    state_d = ST_IDLE;
                else if (finish) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        busy   = 1'b0;
        run_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                busy   = 1'b1;
                run_en = !stop_req;
            end
            default: ;
        endcase
    end

    assign finish = smp_tick && (idx_q == last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            scnt_q <= '0;
            per_q  <= PER_W'(1);
            idx_q  <= '0;
        end else begin
            if (wr_ctrl && (!busy || stop_req))
                ctrl_q <= '{len: bus_wdata[5:4], speed: bus_wdata[3:2], en: bus_wdata[1]};
            if (wr_scnt)
                scnt_q <= bus_wdata[CNT_W-1:0];
            if (!busy && launch_req) begin
                per_q <= PER_W'(eff_cnt) << bus_wdata[3:2];
                idx_q <= '0;
            end else if (smp_tick) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    srng_tick #(.PER_W(PER_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(run_en), .per_i(per_q), .tick_o(smp_tick)
    );

    srng_lfsr #(.W(WORD_W), .SEED(SEED), .TAPS(TAPS)) u_src (
        .clk(clk), .rst_n(rst_n), .step_i(smp_tick), .bit_o(smp_bit)
    );

    srng_collect #(.BITS(BITS), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_tick), .idx_i(idx_q),
        .bit_i(smp_bit), .acc_nxt_o(acc_nxt)
    );

    // result words, all updated in the finish cycle
    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                out_q[gi] <= '0;
            else if (finish)
                out_q[gi] <= (NW_W'(gi) < nwords_req) ? acc_nxt[gi*WORD_W +: WORD_W] : '0;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFF))
            bus_rdata = 32'({ctrl_q.len, ctrl_q.speed, ctrl_q.en, busy});
        else if (bus_addr == ADDR_W'(SCNT_OFF))
            bus_rdata = 32'(scnt_q);
        for (int i = 0; i < NWORDS; i++)
            if (bus_addr == ADDR_W'(OUT_OFF + 4 * i))
                bus_rdata = out_q[i];
    end
endmodule

// File: rtl/startbit_rng_chk.sv
module startbit_rng_chk
    import srng_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NWORDS = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [31:0]              bus_wdata,
    input logic                     busy,
    input logic                     smp_tick,
    input logic                     finish,
    input logic [NWORDS*WORD_W-1:0] words
);
    logic ctrl_wr;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(CTRL_OFF));

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctrl_wr && bus_wdata[1:0] == 2'b11) |=> busy);

    // R9
    noen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctrl_wr && bus_wdata[1:0] == 2'b01) |=> (!busy && $stable(words)));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr && bus_wdata[15:0] == 16'h0) |=> (!busy && $stable(words)));

    // R8
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> $stable(words));

    // R7
    sample_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |-> busy);
endmodule

bind startbit_rng startbit_rng_chk #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
    .smp_tick(smp_tick), .finish(finish), .words(out_q)
);

// File: tb/startbit_rng_bench.sv
`timescale 1ns/1ps
module startbit_rng_bench;
    localparam logic [11:0] A_CTRL = 12'h400;
    localparam logic [11:0] A_SCNT = 12'h404;
    localparam logic [11:0] A_OUT  = 12'h410;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_cmp = 0, n_bad = 0;
    int unsigned cyc = 0;
    logic [31:0] m_src = 32'hACE1_2468;
    logic [31:0] exp_w [8];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    startbit_rng u_startbit_rng (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] src_next(input logic [31:0] s);
        logic [31:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ 32'h8020_0003;
        return n;
    endfunction

    function automatic logic [31:0] ctrl_word(input int len, input int spd, input bit en, input bit st);
        return 32'((len << 4) | (spd << 2) | (int'(en) << 1) | int'(st));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_words(input string req);
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(A_OUT + 12'(4 * i), v);
            chk(req, v, exp_w[i]);
        end
    endtask

    task automatic model_steps(input int n);
        for (int k = 0; k < n; k++) m_src = src_next(m_src);
    endtask

    task automatic model_result(input int len);
        int nb;
        logic [255:0] bits;
        nb = (len + 1) * 64;
        bits = '0;
        for (int k = 0; k < nb; k++) begin
            m_src = src_next(m_src);
            bits[k] = m_src[0];
        end
        for (int i = 0; i < 8; i++)
            exp_w[i] = (i < (len + 1) * 2) ? bits[i*32 +: 32] : 32'h0;
    endtask

    task automatic wait_done(output int unsigned lat, input int unsigned c0);
        logic [31:0] v;
        forever begin
            rd(A_CTRL, v);
            if (!v[0]) break;
            @(negedge clk);
        end
        lat = cyc - c0;
    endtask

    // full request: launch, check hold, wait, check latency and words
    task automatic run_req(input int cnt, input int spd, input int len);
        logic [31:0] v;
        int unsigned c0, lat, per;
        wr(A_SCNT, 32'(cnt));
        wr(A_CTRL, ctrl_word(len, spd, 1'b1, 1'b1));
        c0 = cyc;
        rd(A_CTRL, v);
        chk("R3 start high while running", {31'h0, v[0]}, 32'h1);
        rd(A_OUT, v);
        chk("R8 word held while running", v, exp_w[0]);
        wait_done(lat, c0);
        per = ((cnt == 0) ? 1 : cnt) << spd;
        chk((cnt == 0) ? "R5 latency with zero count" : "R4 latency for speed/count",
            lat, (len + 1) * 64 * per);
        model_result(len);
        check_words((len == 3) ? "R7 words" : "R6 words and zero fill");
        rd(A_CTRL, v);
        chk("R2 control readback after finish", v, ctrl_word(len, spd, 1'b1, 1'b0));
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned c0, lat;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) exp_w[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 control after reset", v, 32'h0);
        rd(A_SCNT, v); chk("R1 count after reset", v, 32'h0);
        check_words("R1 words after reset");

        // R2 sample count readback
        wr(A_SCNT, 32'h0001_BEEF);
        rd(A_SCNT, v); chk("R2 count readback", v, 32'h0000_BEEF);

        // R9 start without enable
        wr(A_CTRL, ctrl_word(2, 1, 1'b0, 1'b1));
        @(negedge clk);
        rd(A_CTRL, v); chk("R9 start ignored without enable", v, 32'h24);
        check_words("R9 words unchanged");

        // R5 zero count, then R4 speed sweep
        run_req(0, 0, 0);
        for (int s = 0; s < 4; s++) run_req(1, s, 0);

        // R10 stop mid-request
        wr(A_SCNT, 32'd2);
        wr(A_CTRL, ctrl_word(1, 0, 1'b1, 1'b1));
        repeat (6) @(negedge clk);
        wr(A_CTRL, 32'hFFFF_0000);
        model_steps(3);
        rd(A_CTRL, v); chk("R10 stop clears control", v, 32'h0);
        check_words("R10 words held after stop");

        // R10 stop in the finish cycle: period 2, 64 bits, stop at 128
        wr(A_SCNT, 32'd1);
        wr(A_CTRL, ctrl_word(0, 1, 1'b1, 1'b1));
        repeat (127) @(negedge clk);
        wr(A_CTRL, 32'h0);
        model_steps(63);
        rd(A_CTRL, v); chk("R10 stop wins over finish", v, 32'h0);
        check_words("R10 words held on colliding stop");
        run_req(1, 0, 1);

        // R11 writes during a running request
        wr(A_SCNT, 32'd2);
        wr(A_CTRL, ctrl_word(0, 0, 1'b1, 1'b1));
        c0 = cyc;
        wr(A_SCNT, 32'd5);
        wr(A_CTRL, ctrl_word(3, 3, 1'b1, 1'b1));
        wait_done(lat, c0);
        chk("R11 latency unaffected by writes", lat, 128);
        model_result(0);
        check_words("R11 words unaffected by writes");
        rd(A_SCNT, v); chk("R11 count stored during run", v, 32'd5);
        rd(A_CTRL, v); chk("R11 control write ignored", v, 32'h2);

        // constrained random requests
        for (int n = 0; n < 8; n++)
            run_req($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
        run_req(3, 3, 3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule